// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block turns three digitised Hall sensor levels into the six gate-drive enables of a three-phase bridge pre-driver: one upper and one lower enable for each phase U, V and W. Each Hall code picks one upper switch and one lower switch of two different phases. A direction input mirrors the code space so that the motor turns the other way. PWM chopping acts only on the chosen upper switch, and the chosen lower switch stays on for the whole commutation step.

Some control inputs change the pattern. A start/stop input parks the bridge in high impedance. A brake request shorts the motor through the three upper switches. A two-bit protection request either removes the upper side alone, which covers undervoltage, overtemperature and locked-rotor faults, or removes everything, which covers reverse-rotation protection. When direction or brake changes, the block holds every switch off for a programmable blanking interval. This stops an upper and a lower switch of one phase from overlapping while the external transistors turn off. A status output gives the registered XOR of the synchronised Hall bits, which toggles on every Hall edge.

Top module: `hall_commutator`

## Requirements
- R1: A change of `hall_in` that is present before rising edge n reaches the gate enables and `hall_sum` on edge n+2, after two synchroniser stages and one output register. Before that edge the old value still shows.
- R2: With `dir_sel`=0, the codes {hall_in[2],hall_in[1],hall_in[0]} 101, 100, 110, 010, 011 and 001 give (upper,lower) pairs (V,U), (W,U), (W,V), (U,V), (U,W) and (V,W). Gate bit 0 is phase U, bit 1 is V and bit 2 is W.
- R3: With `dir_sel`=1, each Hall code is bitwise inverted and then looked up as in R2. For example, code 010 gives (V,U).
- R4: Hall codes 000 and 111 turn all six enables off.
- R5: The selected upper enable is on only while `pwm_in_n`=0 and `pwm_strobe`=1. The selected lower enable does not depend on either input.
- R6: While `stop_req`=1 every enable is off and all six bits of `gate_hiz` are 1. Otherwise `gate_hiz` is 0. Stop overrides every other input.
- R7: While `brake_n`=0, after blanking, all three upper enables are on and all three lower enables are off, whatever the Hall code and PWM inputs are.
- R8: `prot_req`=01 clears the three upper enables and leaves the lower enables as the other inputs set them.
- R9: `prot_req`=10 or 11 turns all six enables off, and `gate_hiz` stays 0.
- R10: When `dir_sel` or `brake_n` changes, all enables are off for DEAD_CYC+1 cycles, from the first edge that samples the new value. The new pattern appears on the following edge.
- R11: In no cycle are the upper and lower enables of the same phase both on.
- R12: `hall_sum` is the XOR of the three synchronised Hall bits, with the latency of R1.
- R13: In reset all enables are off, `gate_hiz` is all ones and `hall_sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_in | input | 3 | Asynchronous Hall levels, bit 2 = sensor 1 |
| dir_sel | input | 1 | Rotation direction, 1 = inverted code |
| brake_n | input | 1 | Short brake request, active low |
| stop_req | input | 1 | Stop, 1 = bridge high impedance |
| pwm_in_n | input | 1 | External PWM pulse, 0 = drive |
| pwm_strobe | input | 1 | Internal PWM on-phase, 1 = drive |
| prot_req | input | 2 | 00 none, 01 upper off, 1x all off |
| gate_hi | output | 3 | Upper enables, bit 0 = U |
| gate_lo | output | 3 | Lower enables, bit 0 = U |
| gate_hiz | output | 6 | High-impedance flags, [2:0] upper, [5:3] lower |
| hall_sum | output | 1 | Registered XOR of the synchronised Hall bits |

## Verification
The hardest case to reach is the edge of the blanking window. The test must show that the enables stay off for exactly DEAD_CYC+1 cycles and then return in the next cycle with no overlap. The stimulus changes direction on a falling edge while a valid Hall code is held steady, then samples just after the last blanked edge and just after the first released edge. Entering and leaving brake get the same treatment, which also covers the move from all uppers on to a commutation pair.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        PROT_NONE  = 2'b00,
        PROT_UPPER = 2'b01,
        PROT_ALL_A = 2'b10,
        PROT_ALL_B = 2'b11
    } prot_e;

    typedef struct packed {
        logic              valid;
        logic [PHASES-1:0] hi;
        logic [PHASES-1:0] lo;
    } drive_t;

    localparam logic [PHASES-1:0] PH_U = 3'b001;
    localparam logic [PHASES-1:0] PH_V = 3'b010;
    localparam logic [PHASES-1:0] PH_W = 3'b100;

    function automatic drive_t pair(logic [PHASES-1:0] up, logic [PHASES-1:0] dn);
        drive_t d;
        d.valid = 1'b1;
        d.hi    = up;
        d.lo    = dn;
        return d;
    endfunction

    // Map a Hall word to one upper and one lower phase; rev mirrors the code.
    function automatic drive_t hall_decode(logic [2:0] code, logic rev);
        logic [2:0] c;
        drive_t     d;
        c = rev ? ~code : code;
        d = '0;
        unique case (c)
            3'b101:  d = pair(PH_V, PH_U);
            3'b100:  d = pair(PH_W, PH_U);
            3'b110:  d = pair(PH_W, PH_V);
            3'b010:  d = pair(PH_U, PH_V);
            3'b011:  d = pair(PH_U, PH_W);
            3'b001:  d = pair(PH_V, PH_W);
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hc_hall_sync.sv
module hc_hall_sync #(
    parameter int WIDTH       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced,
    output logic             parity
);
    logic [WIDTH-1:0] stage [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= raw;
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign synced = stage[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) parity <= 1'b0;
        else     parity <= ^synced;
    end
endmodule

// File: rtl/hc_blanking.sv
module hc_blanking #(
    parameter int DEAD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_sel,
    input  logic brake_n,
    output logic blank
);
    localparam int CW = $clog2(DEAD_CYC + 1) + 1;

    logic          dir_prev;
    logic          brk_prev;
    logic [CW-1:0] cnt;
    logic          change;

    assign change = (dir_sel != dir_prev) || (brake_n != brk_prev);
    assign blank  = change || (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_prev <= 1'b0;
            brk_prev <= 1'b1;
            cnt      <= '0;
        end else begin
            dir_prev <= dir_sel;
            brk_prev <= brake_n;
            if (change)          cnt <= CW'(DEAD_CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hc_gate_stage.sv
module hc_gate_stage
    import hc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  drive_t              drv,
    input  logic                blank,
    input  logic                brake_n,
    input  logic                stop_req,
    input  logic                chop_on,
    input  prot_e               prot,
    output logic [PHASES-1:0]   gate_hi,
    output logic [PHASES-1:0]   gate_lo,
    output logic [2*PHASES-1:0] gate_hiz
);
    logic [PHASES-1:0]   nxt_hi;
    logic [PHASES-1:0]   nxt_lo;
    logic [2*PHASES-1:0] nxt_hiz;
    logic                kill_all;
    logic                kill_up;

    assign kill_all = (prot == PROT_ALL_A) || (prot == PROT_ALL_B);
    assign kill_up  = (prot == PROT_UPPER);

    always_comb begin
        nxt_hi  = '0;
        nxt_lo  = '0;
        nxt_hiz = {(2*PHASES){stop_req}};
        if (!stop_req && !kill_all && !blank) begin
            if (!brake_n) begin
                nxt_hi = '1;
            end else if (drv.valid) begin
                nxt_hi = drv.hi & {PHASES{chop_on}};
                nxt_lo = drv.lo;
            end
            if (kill_up) nxt_hi = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_hi  <= '0;
            gate_lo  <= '0;
            gate_hiz <= '1;
        end else begin
            gate_hi  <= nxt_hi;
            gate_lo  <= nxt_lo;
            gate_hiz <= nxt_hiz;
        end
    end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hc_pkg::*;
#(
    parameter int DEAD_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_sel,
    input  logic       brake_n,
    input  logic       stop_req,
    input  logic       pwm_in_n,
    input  logic       pwm_strobe,
    input  logic [1:0] prot_req,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic [5:0] gate_hiz,
    output logic       hall_sum
);
    logic [2:0] hall_s;
    logic       blank;
    drive_t     drv;
    logic       chop_on;

    hc_hall_sync #(.WIDTH(3), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (hall_in),
        .synced (hall_s),
        .parity (hall_sum)
    );

    hc_blanking #(.DEAD_CYC(DEAD_CYC)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .dir_sel (dir_sel),
        .brake_n (brake_n),
        .blank   (blank)
    );

    assign drv     = hall_decode(hall_s, dir_sel);
    assign chop_on = pwm_strobe & ~pwm_in_n;

    hc_gate_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .drv      (drv),
        .blank    (blank),
        .brake_n  (brake_n),
        .stop_req (stop_req),
        .chop_on  (chop_on),
        .prot     (prot_e'(prot_req)),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo),
        .gate_hiz (gate_hiz)
    );
endmodule

// File: rtl/hc_checker.sv
module hc_checker (
    input logic       clk,
    input logic       rst,
    input logic       dir_sel,
    input logic       brake_n,
    input logic       stop_req,
    input logic       pwm_in_n,
    input logic       pwm_strobe,
    input logic [1:0] prot_req,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic [5:0] gate_hiz
);
    logic dir_d, brk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_d <= 1'b0;
            brk_d <= 1'b1;
        end else begin
            dir_d <= dir_sel;
            brk_d <= brake_n;
        end
    end

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b000);  // R11

    AST_STOP_HIZ: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && gate_hiz == 6'h3f));  // R6

    AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        prot_req[1] |=> (gate_hi == 3'b000 && gate_lo == 3'b000));  // R9

    AST_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
        (prot_req == 2'b01) |=> (gate_hi == 3'b000));  // R8

    AST_BRAKE_NO_LOW: assert property (@(posedge clk) disable iff (rst)
        !brake_n |=> (gate_lo == 3'b000));  // R7

    AST_CHOP_UPPER: assert property (@(posedge clk) disable iff (rst)
        (brake_n && (pwm_in_n || !pwm_strobe)) |=> (gate_hi == 3'b000));  // R5

    AST_BLANK_START: assert property (@(posedge clk) disable iff (rst)
        ((dir_sel != dir_d) || (brake_n != brk_d)) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));  // R10

    AST_SINGLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (gate_lo != 3'b000) |-> ($onehot0(gate_hi) && $onehot(gate_lo)));  // R2
endmodule

bind hall_commutator hc_checker u_hc_checker (
    .clk        (clk),
    .rst        (rst),
    .dir_sel    (dir_sel),
    .brake_n    (brake_n),
    .stop_req   (stop_req),
    .pwm_in_n   (pwm_in_n),
    .pwm_strobe (pwm_strobe),
    .prot_req   (prot_req),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .gate_hiz   (gate_hiz)
);

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
    localparam int DEAD = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hall_in;
    logic       dir_sel, brake_n, stop_req, pwm_in_n, pwm_strobe;
    logic [1:0] prot_req;
    logic [2:0] gate_hi, gate_lo;
    logic [5:0] gate_hiz;
    logic       hall_sum;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hall_commutator #(.DEAD_CYC(DEAD)) i_hall_commutator (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_sel(dir_sel),
        .brake_n(brake_n), .stop_req(stop_req), .pwm_in_n(pwm_in_n),
        .pwm_strobe(pwm_strobe), .prot_req(prot_req), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .gate_hiz(gate_hiz), .hall_sum(hall_sum)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    // Expected {upper,lower} from the R2/R3 tables
    function automatic logic [5:0] exp_pair(logic [2:0] code, logic rev);
        logic [2:0] c = rev ? ~code : code;
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R13", "hi", gate_hi, 0);
        chk("R13", "lo", gate_lo, 0);
        chk("R13", "hiz", gate_hiz, 6'h3f);
        chk("R13", "sum", hall_sum, 0);
    endtask

    task automatic t_table(logic rev, string req);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) hall_in = 3'(i);
            settle(4);
            chk((i == 0 || i == 7) ? "R4" : req, "pair", {gate_hi, gate_lo}, exp_pair(3'(i), rev));
            chk("R12", "sum", hall_sum, ^(3'(i)));
            chk("R6", "hiz run", gate_hiz, 0);
        end
    endtask

    task automatic t_latency;
        @(negedge clk) hall_in = 3'b101;
        settle(4);
        @(negedge clk) hall_in = 3'b100;
        settle(2);
        chk("R1", "old pair", {gate_hi, gate_lo}, exp_pair(3'b101, 1'b0));
        chk("R1", "old sum", hall_sum, 0);
        settle(1);
        chk("R1", "new pair", {gate_hi, gate_lo}, exp_pair(3'b100, 1'b0));
        chk("R1", "new sum", hall_sum, 1);
    endtask

    task automatic t_dir_blank;
        @(negedge clk) hall_in = 3'b110;
        settle(4);
        @(negedge clk) dir_sel = 1'b1;
        settle(1);
        chk("R10", "first blank", {gate_hi, gate_lo}, 0);
        settle(DEAD);
        chk("R10", "last blank", {gate_hi, gate_lo}, 0);
        settle(1);
        chk("R10", "released", {gate_hi, gate_lo}, exp_pair(3'b110, 1'b1));
    endtask

    task automatic t_pwm;
        @(negedge clk) begin hall_in = 3'b011; pwm_in_n = 1'b1; end
        settle(4);
        chk("R5", "pwm_n high hi", gate_hi, 0);
        chk("R5", "pwm_n high lo", gate_lo, 3'b100);
        @(negedge clk) begin pwm_in_n = 1'b0; pwm_strobe = 1'b0; end
        settle(2);
        chk("R5", "strobe low hi", gate_hi, 0);
        chk("R5", "strobe low lo", gate_lo, 3'b100);
        @(negedge clk) pwm_strobe = 1'b1;
        settle(2);
        chk("R5", "both on", gate_hi, 3'b001);
    endtask

    task automatic t_brake;
        @(negedge clk) begin hall_in = 3'b101; brake_n = 1'b0; end
        settle(DEAD + 1);
        chk("R10", "brake blank end", {gate_hi, gate_lo}, 0);
        settle(1);
        chk("R7", "brake", {gate_hi, gate_lo}, 6'b111_000);
        @(negedge clk) pwm_in_n = 1'b1;
        settle(2);
        chk("R7", "brake unchopped", {gate_hi, gate_lo}, 6'b111_000);
        @(negedge clk) begin pwm_in_n = 1'b0; brake_n = 1'b1; end
        settle(DEAD + 1);
        chk("R10", "release blank", {gate_hi, gate_lo}, 0);
        settle(1);
        chk("R11", "after brake", {gate_hi, gate_lo}, exp_pair(3'b101, 1'b0));
    endtask

    task automatic t_prot;
        @(negedge clk) begin hall_in = 3'b010; prot_req = 2'b01; end
        settle(4);
        chk("R8", "upper off", gate_hi, 0);
        chk("R8", "lower kept", gate_lo, 3'b010);
        @(negedge clk) prot_req = 2'b10;
        settle(2);
        chk("R9", "all off 10", {gate_hi, gate_lo}, 0);
        chk("R9", "no hiz", gate_hiz, 0);
        @(negedge clk) prot_req = 2'b11;
        settle(2);
        chk("R9", "all off 11", {gate_hi, gate_lo}, 0);
        @(negedge clk) prot_req = 2'b00;
        settle(2);
        chk("R8", "restored", {gate_hi, gate_lo}, exp_pair(3'b010, 1'b0));
    endtask

    task automatic t_stop;
        @(negedge clk) begin stop_req = 1'b1; brake_n = 1'b1; end
        settle(2);
        chk("R6", "stop gates", {gate_hi, gate_lo}, 0);
        chk("R6", "stop hiz", gate_hiz, 6'h3f);
        @(negedge clk) stop_req = 1'b0;
        settle(2);
        chk("R6", "resume", {gate_hi, gate_lo}, exp_pair(3'b010, 1'b0));
        chk("R6", "resume hiz", gate_hiz, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hall_in = 3'b000; dir_sel = 1'b0; brake_n = 1'b1;
        stop_req = 1'b0; pwm_in_n = 1'b0; pwm_strobe = 1'b1; prot_req = 2'b00;
        settle(3);
        t_reset;
        @(negedge clk) rst = 1'b0;
        t_table(1'b0, "R2");
        t_latency;
        t_dir_blank;
        t_table(1'b1, "R3");
        @(negedge clk) dir_sel = 1'b0;
        settle(DEAD + 3);
        t_pwm;
        t_brake;
        t_prot;
        t_stop;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule